// File: doc/BRIEF.md
# Paired-Register Timer Compare Unit

This block compares one free-running up-counter against sixteen 16-bit compare registers and drives sixteen output pins from the results. The counter starts at a programmable reload value and counts up to the all-ones value. On the next step it wraps back to the reload value. A compare value below the reload value can therefore never be reached. Software loads compare values through a simple write port that carries an index, the data and a strobe.

The registers form two banks. Indices 0 to 7 are the lower bank and indices 8 to 15 are the upper bank. Each pair, made of register i and register i+8, has its own mode bit. With the bit clear, each register of the pair drives its own pin: a match sets the pin and the wrap clears it. With the bit set, both registers act on pin i. The lower-bank match sets that pin and the upper-bank match clears it, and pin i+8 is held low.

Each register can match at most once per timer period. A value written after the register has already matched in the period waits for the next wrap. A value written before the register has matched takes effect at once.

Top module: `pair_cmp_unit`

## Requirements
- R1: While `rst` is high, every compare register and every mode bit is cleared, all pins are 0, and the timer holds the value on `reload_i`.
- R2: Out of reset the timer increments by one per cycle. In the cycle after it holds 16'hFFFF (the wrap cycle), it holds the value `reload_i` had in the wrap cycle.
- R3: A register matches in a cycle where the timer equals its active value and the register has not matched yet in the current period. Its pin responds at the next clock edge. A register loaded with the reload value matches in the first cycle after a wrap. A value below the reload value never matches.
- R4: After a register matches, it cannot match again before the next wrap. A value written to it after the match, or in the cycle of the match, becomes active at the wrap.
- R5: A write to a register that has not matched in the current period becomes active at the next clock edge, and it can still match in the same period. A write in the wrap cycle is active for the new period.
- R6: Single mode, where mode bit i is 0 (this governs pins i and i+8): a match sets the register's own pin to 1, and a wrap cycle clears it to 0. If a match and a wrap fall in the same cycle, the pin becomes 1.
- R7: Double mode, where mode bit i is 1: a match of register i sets pin i, and a match of register i+8 clears pin i. If both match in one cycle, the pin becomes 0. A wrap leaves pin i unchanged. Pin i+8 is driven to 0.
- R8: A cycle with `mode_we_i` high loads `mode_data_i` into the mode bits. Bit i selects double mode for the pair made of register i and register i+8. `wr_idx_i` values 0 to 7 address the lower bank and 8 to 15 address the upper bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_i | input | 16 | Timer restart value, used at reset and at each wrap |
| wr_en_i | input | 1 | Compare register write strobe |
| wr_idx_i | input | 4 | Compare register index |
| wr_data_i | input | 16 | Compare value to write |
| mode_we_i | input | 1 | Mode bit write strobe |
| mode_data_i | input | 8 | One double-mode bit per register pair |
| tmr_o | output | 16 | Current timer value |
| pin_o | output | 16 | Output pins, one per register |

## Verification
The assertions are written for a reset held high from the first clock edge. After the wrap, the timer is checked against the `reload_i` value of the wrap cycle, so the bench changes `reload_i` only between negative clock edges. The per-register checks assume that a single index is written per cycle, which the one-index write port guarantees. The stimulus keeps the reload value and all compare values in the top few dozen counts of the range. A period then lasts at most 64 cycles, which forces frequent wraps, blocked rewrites and coincident matches. Some compare values are placed below the reload value on purpose.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned PCU_CW   = 16;
    localparam int unsigned PCU_NREG = 16;

    // State kept per compare register
    typedef struct packed {
        logic              blocked;
        logic              pend_v;
        logic [PCU_CW-1:0] pend;
        logic [PCU_CW-1:0] act;
    } slot_st_t;

    // Next pin level from set and clear requests; clr_wins picks the tie winner
    function automatic logic pin_step(input logic cur, input logic set,
                                      input logic clr, input logic clr_wins);
        logic nxt;
        if (set && clr)  nxt = !clr_wins;
        else if (set)    nxt = 1'b1;
        else if (clr)    nxt = 1'b0;
        else             nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/pcu_timer.sv
module pcu_timer #(
    parameter int unsigned CW = pcu_pkg::PCU_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] reload_i,
    output logic [CW-1:0] tmr_o,
    output logic          ovf_o
);
    localparam logic [CW-1:0] TMAX = '1;

    logic [CW-1:0] tmr_q;

    assign ovf_o = (tmr_q == TMAX);
    assign tmr_o = tmr_q;

    always_ff @(posedge clk) begin
        if (rst || ovf_o) tmr_q <= reload_i;
        else              tmr_q <= tmr_q + 1'b1;
    end

    // R2: plain step away from the wrap
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (tmr_o != TMAX) |=> (tmr_o == $past(tmr_o) + 1'b1));
    // R2: wrap restarts from reload
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (tmr_o == TMAX) |=> (tmr_o == $past(reload_i)));

endmodule

// File: rtl/pcu_slot.sv
module pcu_slot #(
    parameter int unsigned CW = pcu_pkg::PCU_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] tmr_i,
    input  logic          ovf_i,
    input  logic          we_i,
    input  logic [CW-1:0] wdata_i,
    output logic          match_o
);
    logic          blocked_q, pend_v_q;
    logic [CW-1:0] pend_q, act_q;

    assign match_o = (tmr_i == act_q) && !blocked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked_q <= 1'b0;
            pend_v_q  <= 1'b0;
            pend_q    <= '0;
            act_q     <= '0;
        end else if (ovf_i) begin
            // New period: blocking ends, deferred value moves in
            blocked_q <= 1'b0;
            pend_v_q  <= 1'b0;
            if (we_i)          act_q <= wdata_i;
            else if (pend_v_q) act_q <= pend_q;
        end else begin
            if (match_o) blocked_q <= 1'b1;
            if (we_i) begin
                if (blocked_q || match_o) begin
                    pend_q   <= wdata_i;
                    pend_v_q <= 1'b1;
                end else begin
                    act_q <= wdata_i;
                end
            end
        end
    end

    // R4: no second match within one period
    a_r4_once: assert property (@(posedge clk) disable iff (rst)
        (match_o && !ovf_i) |=> !match_o);
    // R4: a write after the match leaves the active value alone
    a_r4_defer: assert property (@(posedge clk) disable iff (rst)
        (we_i && !ovf_i && (blocked_q || match_o)) |=> $stable(act_q));
    // R5: a write before any match is active at once
    a_r5_now: assert property (@(posedge clk) disable iff (rst)
        (we_i && !ovf_i && !blocked_q && !match_o) |=> (act_q == $past(wdata_i)));

endmodule

// File: rtl/pcu_pins.sv
module pcu_pins #(
    parameter int unsigned NREG = pcu_pkg::PCU_NREG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREG-1:0]   match_i,
    input  logic              ovf_i,
    input  logic [NREG/2-1:0] dbl_i,
    output logic [NREG-1:0]   pin_o
);
    localparam int unsigned NPAIR = NREG / 2;

    logic [NREG-1:0] pin_q;
    assign pin_o = pin_q;

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        localparam int unsigned HI = i + NPAIR;

        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q[i]  <= 1'b0;
                pin_q[HI] <= 1'b0;
            end else if (dbl_i[i]) begin
                pin_q[i]  <= pcu_pkg::pin_step(pin_q[i], match_i[i], match_i[HI], 1'b1);
                pin_q[HI] <= 1'b0;
            end else begin
                pin_q[i]  <= pcu_pkg::pin_step(pin_q[i], match_i[i], ovf_i, 1'b0);
                pin_q[HI] <= pcu_pkg::pin_step(pin_q[HI], match_i[HI], ovf_i, 1'b0);
            end
        end

        // R6: single-mode match raises the pin
        a_r6_set: assert property (@(posedge clk) disable iff (rst)
            (!dbl_i[i] && match_i[i]) |=> pin_o[i]);
        // R6: wrap without a match drops the pin
        a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
            (!dbl_i[i] && ovf_i && !match_i[HI]) |=> !pin_o[HI]);
        // R7: upper-bank match clears the shared pin, also on a tie
        a_r7_clr: assert property (@(posedge clk) disable iff (rst)
            (dbl_i[i] && match_i[HI]) |=> !pin_o[i]);
        // R7: wrap leaves the shared pin unchanged
        a_r7_hold: assert property (@(posedge clk) disable iff (rst)
            (dbl_i[i] && !match_i[i] && !match_i[HI]) |=> (pin_o[i] == $past(pin_o[i])));
        // R7: upper pin of a joined pair stays low
        a_r7_hi_low: assert property (@(posedge clk) disable iff (rst)
            dbl_i[i] |=> !pin_o[HI]);
    end

endmodule

// File: rtl/pair_cmp_unit.sv
module pair_cmp_unit #(
    parameter int unsigned CW   = pcu_pkg::PCU_CW,
    parameter int unsigned NREG = pcu_pkg::PCU_NREG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CW-1:0]           reload_i,
    input  logic                    wr_en_i,
    input  logic [$clog2(NREG)-1:0] wr_idx_i,
    input  logic [CW-1:0]           wr_data_i,
    input  logic                    mode_we_i,
    input  logic [NREG/2-1:0]       mode_data_i,
    output logic [CW-1:0]           tmr_o,
    output logic [NREG-1:0]         pin_o
);
    localparam int unsigned NPAIR = NREG / 2;
    localparam int unsigned IDXW  = $clog2(NREG);

    logic              ovf;
    logic [NREG-1:0]   match;
    logic [NPAIR-1:0]  dbl_q;

    always_ff @(posedge clk) begin
        if (rst)            dbl_q <= '0;
        else if (mode_we_i) dbl_q <= mode_data_i;
    end

    pcu_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .reload_i (reload_i),
        .tmr_o    (tmr_o),
        .ovf_o    (ovf)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        pcu_slot #(.CW(CW)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .tmr_i   (tmr_o),
            .ovf_i   (ovf),
            .we_i    (wr_en_i && (wr_idx_i == IDXW'(k))),
            .wdata_i (wr_data_i),
            .match_o (match[k])
        );
    end

    pcu_pins #(.NREG(NREG)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .match_i (match),
        .ovf_i   (ovf),
        .dbl_i   (dbl_q),
        .pin_o   (pin_o)
    );

    // R1: reset drives every pin low and loads the timer
    a_r1_reset: assert property (@(posedge clk)
        rst |=> ((pin_o == '0) && (tmr_o == $past(reload_i))));

endmodule

// File: tb/test_pair_cmp_unit.sv
module test_pair_cmp_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] reload_i = 16'hFFF0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        mode_we_i = 1'b0;
    logic [7:0]  mode_data_i = '0;
    logic [15:0] tmr_o;
    logic [15:0] pin_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    pair_cmp_unit i_pair_cmp_unit (
        .clk(clk), .rst(rst), .reload_i(reload_i), .wr_en_i(wr_en_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .mode_we_i(mode_we_i),
        .mode_data_i(mode_data_i), .tmr_o(tmr_o), .pin_o(pin_o)
    );

    // Reference model built from the requirements
    logic [15:0] m_act [16];
    logic [15:0] m_pend [16];
    logic        m_pv [16];
    logic        m_blk [16];
    logic [15:0] m_pin;
    logic [7:0]  m_mode;
    logic [15:0] m_tmr;
    logic [15:0] mm;
    logic        mo;

    function automatic logic nxt_pin(logic cur, logic s, logic c, logic clr_first);
        if (s && c) return !clr_first;
        if (s) return 1'b1;
        if (c) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) begin
                m_act[k] = '0; m_pend[k] = '0; m_pv[k] = 1'b0; m_blk[k] = 1'b0;
            end
            m_pin = '0; m_mode = '0; m_tmr = reload_i;
        end else begin
            mo = (m_tmr == 16'hFFFF);
            for (int k = 0; k < 16; k++) mm[k] = (m_tmr == m_act[k]) && !m_blk[k];
            for (int i = 0; i < 8; i++) begin
                if (m_mode[i]) begin   // R7
                    m_pin[i]   = nxt_pin(m_pin[i], mm[i], mm[i+8], 1'b1);
                    m_pin[i+8] = 1'b0;
                end else begin         // R6
                    m_pin[i]   = nxt_pin(m_pin[i], mm[i], mo, 1'b0);
                    m_pin[i+8] = nxt_pin(m_pin[i+8], mm[i+8], mo, 1'b0);
                end
            end
            for (int k = 0; k < 16; k++) begin
                logic w;
                w = wr_en_i && (wr_idx_i == 4'(k));
                if (mo) begin
                    m_blk[k] = 1'b0;
                    if (w) m_act[k] = wr_data_i;
                    else if (m_pv[k]) m_act[k] = m_pend[k];
                    m_pv[k] = 1'b0;
                end else begin
                    if (w) begin
                        if (m_blk[k] || mm[k]) begin m_pend[k] = wr_data_i; m_pv[k] = 1'b1; end
                        else m_act[k] = wr_data_i;
                    end
                    if (mm[k]) m_blk[k] = 1'b1;
                end
            end
            if (mode_we_i) m_mode = mode_data_i;
            m_tmr = mo ? reload_i : m_tmr + 16'd1;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at tmr=%h", tag, act, exp, tmr_o);
        end
    endtask

    // Continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 timer", tmr_o, m_tmr);
            chk("R6 R7 pins", pin_o, m_pin);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=60000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] idx, input logic [15:0] d);
        wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic mode_wr(input logic [7:0] d);
        mode_we_i = 1'b1; mode_data_i = d;
        @(negedge clk);
        mode_we_i = 1'b0;
    endtask

    task automatic wait_tmr(input logic [15:0] v);
        do @(negedge clk); while (tmr_o !== v);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset pins", pin_o, 16'h0000);
        chk("R1 reset timer", tmr_o, 16'hFFF0);
        rst = 1'b0;

        wr(4'd0, 16'hFFF4);
        wr(4'd1, 16'hFFF0);
        wr(4'd2, 16'hFFE0);
        wait_tmr(16'hFFFF);
        wait_tmr(16'hFFF1);
        chk("R3 reload-equal match", 16'(pin_o[1]), 16'h1);
        wait_tmr(16'hFFF5);
        chk("R3 match sets pin0", 16'(pin_o[0]), 16'h1);
        wait_tmr(16'hFFF1);
        chk("R6 wrap clears pin0", 16'(pin_o[0]), 16'h0);
        wait_tmr(16'hFFFF);
        chk("R3 below reload never matches", 16'(pin_o[2]), 16'h0);

        wait_tmr(16'hFFF6);
        wr(4'd0, 16'hFFF8);           // blocked: deferred to next period
        wait_tmr(16'hFFF5);
        chk("R4 deferred value not yet matched", 16'(pin_o[0]), 16'h0);
        wait_tmr(16'hFFF9);
        chk("R4 deferred value active after wrap", 16'(pin_o[0]), 16'h1);

        wait_tmr(16'hFFF2);
        wr(4'd4, 16'hFFF6);           // not matched yet: same period
        wait_tmr(16'hFFF7);
        chk("R5 same-period write matches", 16'(pin_o[4]), 16'h1);

        mode_wr(8'h08);
        wr(4'd3, 16'hFFF2);
        wr(4'd11, 16'hFFF6);
        wait_tmr(16'hFFFF);
        wait_tmr(16'hFFF3);
        chk("R7 bank1 sets shared pin", 16'(pin_o[3]), 16'h1);
        wait_tmr(16'hFFF7);
        chk("R7 bank2 clears shared pin", 16'(pin_o[3]), 16'h0);
        chk("R8 upper pin of joined pair low", 16'(pin_o[11]), 16'h0);
        wr(4'd3, 16'hFFF9);
        wait_tmr(16'hFFFF);
        wait_tmr(16'hFFFA);
        chk("R7 set before wrap", 16'(pin_o[3]), 16'h1);
        wait_tmr(16'hFFF1);
        chk("R7 wrap leaves shared pin", 16'(pin_o[3]), 16'h1);
        wr(4'd11, 16'hFFF9);
        wait_tmr(16'hFFFF);
        wait_tmr(16'hFFFA);
        chk("R7 tie clears shared pin", 16'(pin_o[3]), 16'h0);

        // Constrained random phase, model-checked every cycle
        for (int n = 0; n < 5000; n++) begin
            int unsigned r;
            r = $urandom % 1000;
            if (r < 250) begin
                wr_en_i = 1'b1; wr_idx_i = 4'($urandom % 16);
                wr_data_i = 16'hFFC0 + 16'($urandom % 64);
            end else wr_en_i = 1'b0;
            if (r >= 970) begin mode_we_i = 1'b1; mode_data_i = 8'($urandom); end
            else mode_we_i = 1'b0;
            if (r == 500) reload_i = ($urandom % 2) ? 16'hFFE0 : 16'hFFD0;
            @(negedge clk);
        end
        wr_en_i = 1'b0; mode_we_i = 1'b0;
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule